// File: doc/BRIEF.md
# Planar Bitplane Pixel Fetch Unit

This block turns a planar raster held in a 16-bit-wide memory into a stream of colour indices, one per pixel, in raster order. A planar image keeps each bit of the colour index in its own bitplane. To build the index of a pixel, the unit has to read the matching word from every plane and take one bit from each.

Software sets the configuration on the input pins and pulses `start`. The configuration covers the row width in bytes, the row count, the plane count (1 to 8), one base address per plane, and a layout select. The layout is either separate planes or planes interleaved row by row. In the interleaved layout the planes follow one another inside every row, so only the first base address is used. The row stride and the plane offsets then follow from the plane count.

For each 16-pixel column group the unit reads one word per plane through a request/acknowledge port, which accepts any read latency. It then shifts the 16 pixels out over a valid/ready stream. Each pixel carries end-of-line and end-of-frame flags. A one-cycle done pulse marks the end of the frame.

Top module: `planar_pixel_fetch`

## Requirements
- R1: Bit p of `pix_index` comes from plane p. All index bits at or above the configured plane count are 0.
- R2: In separate-plane layout, the read for plane p, row y and word column w uses the byte address `base[p] + y*row_bytes + 2*w`. Plane p's base is bits `[24p+23:24p]` of `cfg_bases`. The memory word at even byte address A carries byte A in bits 15:8 and byte A+1 in bits 7:0.
- R3: Pixel x of a row takes bit `15 - (x mod 16)` of the word in column `x/16`, so the leftmost pixel comes from the most significant bit.
- R4: In interleaved layout, the read address is `base[0] + y*row_bytes*depth + p*row_bytes + 2*w`. The other base fields are ignored.
- R5: A `start` is rejected when `row_bytes` is odd or zero, when `rows` is zero, or when `depth` lies outside 1..8. A rejected start sets `cfg_error`, issues no memory request and produces no pixel. The next accepted `start` clears `cfg_error`.
- R6: For each column group, the unit reads planes 0 to depth-1 in order, one request per plane, before it presents any pixel of that group. `mem_req` is never high while `pix_valid` is high.
- R7: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_index`, `pix_eol` and `pix_eof` hold their values.
- R8: `pix_eol` is high on the last pixel of every row. `pix_eof` is high only on the last pixel of the last row.
- R9: `done` is high for exactly one cycle, in the cycle after the final pixel is accepted. `busy` is low from that cycle on.
- R10: Once raised, `mem_req` stays high with a constant `mem_addr` until `mem_ack` is seen. The read data is taken in the acknowledge cycle.
- R11: After reset, `busy`, `done`, `cfg_error`, `mem_req` and `pix_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the configuration and begin a frame |
| cfg_row_bytes | input | 12 | Bytes per row of one plane |
| cfg_rows | input | 12 | Number of rows |
| cfg_depth | input | 4 | Plane count |
| cfg_interleaved | input | 1 | 1 = row-interleaved layout |
| cfg_bases | input | 192 | Eight 24-bit plane base addresses |
| busy | output | 1 | Frame in progress |
| cfg_error | output | 1 | Last start was rejected |
| done | output | 1 | One-cycle end-of-frame pulse |
| mem_req | output | 1 | Read request |
| mem_addr | output | 24 | Byte address of the word to read |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_data | input | 16 | Read data |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts pixel |
| pix_index | output | 8 | Colour index |
| pix_eol | output | 1 | Last pixel of a row |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The bench sweeps every plane count in both layouts, on top of several odd shapes that include one-word rows and single-row frames. It sets the unused base fields to junk, so an interleaved design that reads a per-plane base fetches the wrong words. A design that mixes up the stride multiply would show the fault from row 1 on, and one with the shift direction reversed would return pixels in mirror order within each word. Memory latency and consumer readiness vary from cycle to cycle, which exposes an index that drifts during a stall, a request whose address moves before it is acknowledged, and a done pulse that arrives early or late. The bench also applies each rejected configuration (odd width, zero plane count, too many planes) and then a good start that must clear the error.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EMIT
  } pfu_state_e;
endpackage

// File: rtl/pfu_addr_gen.sv
// Address generator: only adders at run time. The row stride is the one
// product, and it is formed from configuration that is already latched.
module pfu_addr_gen #(
  parameter int ADDR_W  = 24,
  parameter int DIM_W   = 12,
  parameter int DEPTH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              interleaved,
  input  logic [DIM_W-1:0]  row_bytes,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [ADDR_W-1:0] plane_base,
  input  logic              plane_step,
  input  logic              plane_clr,
  input  logic              word_step,
  input  logic              word_clr,
  input  logic              row_step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] row_base_q, row_base_d;
  logic [ADDR_W-1:0] plane_off_q, plane_off_d;
  logic [ADDR_W-1:0] word_off_q, word_off_d;

  assign stride = interleaved ? ADDR_W'(row_bytes) * ADDR_W'(depth)
                              : ADDR_W'(row_bytes);

  always_comb begin
    row_base_d  = row_base_q;
    plane_off_d = plane_off_q;
    word_off_d  = word_off_q;
    if (ld) begin
      row_base_d  = '0;
      plane_off_d = '0;
      word_off_d  = '0;
    end else begin
      if (plane_clr)
        plane_off_d = '0;
      else if (plane_step && interleaved)
        plane_off_d = plane_off_q + ADDR_W'(row_bytes);
      if (word_clr)
        word_off_d = '0;
      else if (word_step)
        word_off_d = word_off_q + ADDR_W'(2);
      if (row_step)
        row_base_d = row_base_q + stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_base_q  <= '0;
      plane_off_q <= '0;
      word_off_q  <= '0;
    end else begin
      row_base_q  <= row_base_d;
      plane_off_q <= plane_off_d;
      word_off_q  <= word_off_d;
    end
  end

  assign addr = plane_base + row_base_q + plane_off_q + word_off_q;
endmodule

// File: rtl/pfu_plane_shifter.sv
// One shift register per plane; the MSB of each one forms one index bit.
module pfu_plane_shifter #(
  parameter int PLANES  = 8,
  parameter int WORD_W  = 16,
  parameter int PSEL_W  = 3,
  parameter int DEPTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [PSEL_W-1:0]  load_sel,
  input  logic [WORD_W-1:0]  load_data,
  input  logic               shift,
  input  logic [DEPTH_W-1:0] depth,
  output logic [PLANES-1:0]  index
);
  for (genvar g = 0; g < PLANES; g++) begin : g_plane
    logic [WORD_W-1:0] sh_q, sh_d;
    logic              ld_me;

    assign ld_me = load && (load_sel == PSEL_W'(g));

    always_comb begin
      sh_d = sh_q;
      if (ld_me)
        sh_d = load_data;
      else if (shift)
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh_q <= '0;
      else
        sh_q <= sh_d;
    end

    assign index[g] = (DEPTH_W'(g) < depth) ? sh_q[WORD_W-1] : 1'b0;
  end
endmodule

// File: rtl/planar_pixel_fetch.sv
// Planar bitplane pixel fetch unit. rst_n is asserted asynchronously and is
// expected to be released synchronously by the reset tree upstream.
module planar_pixel_fetch #(
  parameter int ADDR_W     = 24,
  parameter int DIM_W      = 12,
  parameter int MAX_PLANES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DIM_W-1:0]             cfg_row_bytes,
  input  logic [DIM_W-1:0]             cfg_rows,
  input  logic [$clog2(MAX_PLANES+1)-1:0] cfg_depth,
  input  logic                         cfg_interleaved,
  input  logic [MAX_PLANES*ADDR_W-1:0] cfg_bases,
  output logic                         busy,
  output logic                         cfg_error,
  output logic                         done,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_ack,
  input  logic [15:0]                  mem_data,
  output logic                         pix_valid,
  input  logic                         pix_ready,
  output logic [MAX_PLANES-1:0]        pix_index,
  output logic                         pix_eol,
  output logic                         pix_eof
);
  import pfu_pkg::*;

  localparam int DEPTH_W = $clog2(MAX_PLANES + 1);
  localparam int PSEL_W  = (MAX_PLANES > 1) ? $clog2(MAX_PLANES) : 1;
  localparam int BIT_W   = $clog2(WORD_W);

  pfu_state_e state_q, state_d;
  logic [PSEL_W-1:0]  plane_q, plane_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [DIM_W-1:0]   word_q, word_d, row_q, row_d;
  logic               err_q, err_d, done_q, done_d;

  logic [DIM_W-1:0]             rb_q, rows_q;
  logic [DEPTH_W-1:0]           depth_q;
  logic                         il_q;
  logic [MAX_PLANES*ADDR_W-1:0] bases_q;

  logic bad_cfg, cfg_ld, fetch_ack, last_plane, take, grp_end;
  logic last_word, last_row;
  logic [ADDR_W-1:0] sel_base;

  // ---- decode ----
  assign bad_cfg = cfg_row_bytes[0] || (cfg_row_bytes == '0) || (cfg_rows == '0)
                || (cfg_depth == '0) || (cfg_depth > DEPTH_W'(MAX_PLANES));
  assign cfg_ld     = (state_q == ST_IDLE) && start && !bad_cfg;
  assign fetch_ack  = (state_q == ST_FETCH) && mem_ack;
  assign last_plane = (DEPTH_W'(plane_q) == depth_q - DEPTH_W'(1));
  assign take       = (state_q == ST_EMIT) && pix_ready;
  assign grp_end    = take && (bit_q == BIT_W'(WORD_W - 1));
  assign last_word  = (word_q == (rb_q >> 1) - DIM_W'(1));
  assign last_row   = (row_q == rows_q - DIM_W'(1));
  assign sel_base   = il_q ? bases_q[ADDR_W-1:0]
                           : bases_q[int'(plane_q)*ADDR_W +: ADDR_W];

  // ---- next state ----
  always_comb begin
    state_d = state_q;
    plane_d = plane_q;
    bit_d   = bit_q;
    word_d  = word_q;
    row_d   = row_q;
    err_d   = err_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          err_d = bad_cfg;
          if (!bad_cfg) begin
            state_d = ST_FETCH;
            plane_d = '0;
            bit_d   = '0;
            word_d  = '0;
            row_d   = '0;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (last_plane) begin
            plane_d = '0;
            state_d = ST_EMIT;
          end else begin
            plane_d = plane_q + PSEL_W'(1);
          end
        end
      end
      ST_EMIT: begin
        if (pix_ready) begin
          bit_d = bit_q + BIT_W'(1);
          if (grp_end) begin
            if (!last_word) begin
              word_d  = word_q + DIM_W'(1);
              state_d = ST_FETCH;
            end else if (!last_row) begin
              word_d  = '0;
              row_d   = row_q + DIM_W'(1);
              state_d = ST_FETCH;
            end else begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      plane_q <= '0;
      bit_q   <= '0;
      word_q  <= '0;
      row_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      plane_q <= plane_d;
      bit_q   <= bit_d;
      word_q  <= word_d;
      row_q   <= row_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_q    <= '0;
      rows_q  <= '0;
      depth_q <= '0;
      il_q    <= 1'b0;
      bases_q <= '0;
    end else if (cfg_ld) begin
      rb_q    <= cfg_row_bytes;
      rows_q  <= cfg_rows;
      depth_q <= cfg_depth;
      il_q    <= cfg_interleaved;
      bases_q <= cfg_bases;
    end
  end

  pfu_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .DEPTH_W(DEPTH_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld         (cfg_ld),
    .interleaved(il_q),
    .row_bytes  (rb_q),
    .depth      (depth_q),
    .plane_base (sel_base),
    .plane_step (fetch_ack && !last_plane),
    .plane_clr  (fetch_ack && last_plane),
    .word_step  (grp_end && !last_word),
    .word_clr   (grp_end && last_word),
    .row_step   (grp_end && last_word && !last_row),
    .addr       (mem_addr)
  );

  pfu_plane_shifter #(.PLANES(MAX_PLANES), .WORD_W(WORD_W), .PSEL_W(PSEL_W),
                      .DEPTH_W(DEPTH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fetch_ack),
    .load_sel (plane_q),
    .load_data(mem_data),
    .shift    (take),
    .depth    (depth_q),
    .index    (pix_index)
  );

  // ---- outputs ----
  assign busy      = (state_q != ST_IDLE);
  assign cfg_error = err_q;
  assign done      = done_q;
  assign mem_req   = (state_q == ST_FETCH);
  assign pix_valid = (state_q == ST_EMIT);
  assign pix_eol   = last_word && (bit_q == BIT_W'(WORD_W - 1));
  assign pix_eof   = pix_eol && last_row;

  // ---- assertions ----
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_index)
                                && $stable(pix_eol) && $stable(pix_eof));

  a_r10_req_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r6_no_fetch_during_emit: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !mem_req);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_eof |=> done && !busy);

  a_r8_eof_implies_eol: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_eof |-> pix_eol);

  a_r1_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ((pix_index >> depth_q) == '0));

  a_r5_error_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !busy && !mem_req);
endmodule

// File: tb/planar_pixel_fetch_bench.sv
`timescale 1ns/1ps
module planar_pixel_fetch_bench;
  localparam int AW = 24;
  localparam int NP = 8;

  logic          clk, rst_n, start;
  logic [11:0]   cfg_row_bytes, cfg_rows;
  logic [3:0]    cfg_depth;
  logic          cfg_interleaved;
  logic [NP*AW-1:0] cfg_bases;
  logic          busy, cfg_error, done, mem_req, mem_ack, pix_valid, pix_ready;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_data;
  logic [NP-1:0] pix_index;
  logic          pix_eol, pix_eof;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  planar_pixel_fetch u_planar_pixel_fetch (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_row_bytes(cfg_row_bytes), .cfg_rows(cfg_rows), .cfg_depth(cfg_depth),
    .cfg_interleaved(cfg_interleaved), .cfg_bases(cfg_bases),
    .busy(busy), .cfg_error(cfg_error), .done(done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index),
    .pix_eol(pix_eol), .pix_eof(pix_eof)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // memory image: word at even byte address a
  function automatic logic [15:0] mw(input logic [AW-1:0] a);
    logic [31:0] t;
    t = {8'h00, a} * 32'd2654435761;
    return t[23:8] ^ {a[7:0], a[15:8]};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int il, input logic [NP*AW-1:0] b,
                                            input int rb, input int d,
                                            input int y, input int p, input int w);
    if (il != 0)
      return b[AW-1:0] + AW'(y*rb*d + p*rb + 2*w);
    return b[p*AW +: AW] + AW'(y*rb + 2*w);
  endfunction

  function automatic logic [NP-1:0] exp_pix(input int il, input logic [NP*AW-1:0] b,
                                           input int rb, input int d,
                                           input int x, input int y);
    logic [NP-1:0] r;
    logic [15:0] wd;
    r = '0;
    for (int p = 0; p < d; p++) begin
      wd = mw(exp_addr(il, b, rb, d, y, p, x / 16));
      r[p] = wd[15 - (x % 16)];
    end
    return r;
  endfunction

  task automatic run_frame(input int rb, input int rows, input int d, input int il,
                           input int rdy_pct, input logic [NP*AW-1:0] b);
    int words, x, y, acks, last_acc, npix;
    bit got_done, prev_wait, prev_stall;
    logic [AW-1:0] held_addr;
    logic [NP-1:0] held_idx, e;
    int g, k, ey, ew;
    words = rb / 2;
    x = 0; y = 0; acks = 0; last_acc = -10; npix = 0;
    got_done = 0; prev_wait = 0; prev_stall = 0;
    held_addr = '0; held_idx = '0;
    @(negedge clk);
    cfg_row_bytes = 12'(rb); cfg_rows = 12'(rows); cfg_depth = 4'(d);
    cfg_interleaved = 1'(il); cfg_bases = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_error == 1'b0, "R5 good start clears error", cfg_error, 0);
    while (!got_done) begin
      if (done) begin
        got_done = 1;
        chk(last_acc == cyc - 1, "R9 done timing", cyc - last_acc, 1);
        chk(npix == rows * rb * 8, "R9 pixel count", npix, rows * rb * 8);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
      end
      if (prev_wait)
        chk(mem_req && mem_addr == held_addr, "R10 request held", mem_addr, held_addr);
      if (prev_stall)
        chk(pix_valid && pix_index == held_idx, "R7 stall hold", pix_index, held_idx);
      // memory side
      mem_ack = mem_req && ($urandom_range(0, 2) == 0);
      if (mem_ack) begin
        g = acks / d; k = acks % d; ey = g / words; ew = g % words;
        chk(mem_addr == exp_addr(il, b, rb, d, ey, k, ew),
            il ? "R4 interleaved address" : "R2 separate address",
            mem_addr, exp_addr(il, b, rb, d, ey, k, ew));
        mem_data = mw(mem_addr);
        acks++;
      end else begin
        mem_data = 16'hDEAD;
      end
      prev_wait = mem_req && !mem_ack;
      held_addr = mem_addr;
      if (pix_valid)
        chk(mem_req == 1'b0, "R6 no request while valid", mem_req, 0);
      // stream side
      pix_ready = ($urandom_range(0, 99) < rdy_pct);
      if (pix_valid && pix_ready) begin
        if (x % 16 == 0)
          chk(acks == (y * words + x / 16 + 1) * d, "R6 planes fetched first",
              acks, (y * words + x / 16 + 1) * d);
        e = exp_pix(il, b, rb, d, x, y);
        chk(pix_index == e, "R1 R3 pixel index", pix_index, e);
        chk(pix_eol == (x == rb * 8 - 1), "R8 end of line", pix_eol, x == rb * 8 - 1);
        chk(pix_eof == (x == rb * 8 - 1 && y == rows - 1), "R8 end of frame",
            pix_eof, x == rb * 8 - 1 && y == rows - 1);
        last_acc = cyc; npix++;
        x++;
        if (x == rb * 8) begin x = 0; y++; end
      end
      prev_stall = pix_valid && !pix_ready;
      held_idx = pix_index;
      @(negedge clk);
    end
    mem_ack = 1'b0; pix_ready = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic bad_start(input int rb, input int rows, input int d, input string why);
    @(negedge clk);
    cfg_row_bytes = 12'(rb); cfg_rows = 12'(rows); cfg_depth = 4'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(cfg_error == 1'b1, {"R5 error flag ", why}, cfg_error, 1);
      chk(!mem_req && !pix_valid && !busy, {"R5 no activity ", why},
          {mem_req, pix_valid, busy}, 0);
      @(negedge clk);
    end
  endtask

  function automatic logic [NP*AW-1:0] mk_bases(input int seed);
    logic [NP*AW-1:0] r;
    for (int p = 0; p < NP; p++)
      r[p*AW +: AW] = AW'(32'h1000 * (p + 1) + 32'h40 * seed + 6 * p);
    return r;
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_ack = 1'b0; mem_data = '0; pix_ready = 1'b0;
    cfg_row_bytes = '0; cfg_rows = '0; cfg_depth = '0; cfg_interleaved = 1'b0;
    cfg_bases = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cfg_error && !mem_req && !pix_valid, "R11 reset state",
        {busy, done, cfg_error, mem_req, pix_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !pix_valid, "R11 idle after reset",
        {busy, mem_req, pix_valid}, 0);

    // sweep every plane count in both layouts
    for (int il = 0; il < 2; il++)
      for (int d = 1; d <= 8; d++)
        run_frame(4, 2, d, il, (d % 2) ? 60 : 100, mk_bases(d + 8 * il));

    // shapes: one-word rows, single row, wide rows
    run_frame(2, 3, 3, 0, 70, mk_bases(20));
    run_frame(6, 2, 8, 1, 50, mk_bases(21));
    run_frame(2, 1, 8, 0, 100, mk_bases(22));
    run_frame(8, 1, 5, 1, 40, mk_bases(23));

    // rejected configurations, then recovery
    bad_start(5, 2, 3, "odd width");
    bad_start(4, 2, 0, "zero planes");
    bad_start(4, 2, 9, "too many planes");
    bad_start(4, 0, 2, "zero rows");
    run_frame(4, 2, 2, 0, 80, mk_bases(30));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule